// File: doc/BRIEF.md
# Chip Reset Sequencer with Start-up Timers

This block gathers every reset request on the die into one chip reset. Its inputs are a power-on detector, a brown-out detector that can be enabled or disabled, an external active-low reset pin, a watchdog timeout pulse and the core's sleep indication. A reset request sets a hold latch that keeps `chip_rst_o` asserted. The latch is released only when every level source has gone away and the start-up timers that the cause calls for have run: a 1024-cycle power-up delay and a 1024-cycle oscillator settle delay.

A watchdog timeout while the core sleeps does not reset anything. It wakes the core: the block waits out the oscillator settle delay when a crystal is in use, then pulses `wake_o`. Four status flags tell software what happened. `to_o` and `pd_o` are set in a pattern that differs for each cause. `por_n_o` and `bor_n_o` are cleared by their own events and set again by software. A 3-bit cause code records the latest event.

The power-on input is also the synchronous active-high reset of the block's own registers. The pin passes through a two-stage synchronizer and then a low-level filter that needs several consecutive low samples.

Top module: `rstc_top`

## Requirements
- R1: While `por_i` is high, `chip_rst_o` is 1, `to_o`=1, `pd_o`=1, `por_n_o`=0, `bor_n_o`=1 and `cause_o`=0. After `por_i` falls, `chip_rst_o` stays 1 for 1024 rising edges, or 2048 when `xtal_mode_i`=1, and then drops.
- R2: When `bor_en_i`=0, `bor_det_i` has no effect: `chip_rst_o` stays 0 and `bor_n_o` stays 1.
- R3: With `bor_en_i`=1, a rising `bor_det_i` asserts `chip_rst_o` on the next edge, clears `bor_n_o` and sets `cause_o`=5. The reset holds while the detector is high and for 1024 edges after it falls, whatever `xtal_mode_i` is. `to_o` and `pd_o` keep their values.
- R4: The pin reset needs `ext_rst_n_i` low for at least 4 consecutive clock samples. A low pulse of 3 cycles never asserts `chip_rst_o`. A low of 4 or more cycles asserts it, and it stays asserted while the pin stays low.
- R5: A pin reset while `sleep_i`=0 sets `cause_o`=1 and leaves `to_o` and `pd_o` unchanged. No timer runs, so `chip_rst_o` drops on the 4th edge after the pin returns high.
- R6: A pin reset while `sleep_i`=1 sets `to_o`=1, `pd_o`=0 and `cause_o`=2. With `xtal_mode_i`=1, `chip_rst_o` stays asserted for 1024 more edges after the pin filter releases.
- R7: A watchdog timeout while running and out of reset gives a `chip_rst_o` pulse exactly one cycle long, with `to_o`=0, `pd_o`=1 and `cause_o`=3.
- R8: A watchdog timeout while `sleep_i`=1 never asserts `chip_rst_o`. It sets `to_o`=0, `pd_o`=0 and `cause_o`=4. `wake_o` pulses for one cycle on the next edge, or 1025 edges later when `xtal_mode_i`=1.
- R9: `sw_set_por_i` sets `por_n_o` and `sw_set_bor_i` sets `bor_n_o` on the next edge. A brown-out event in the same cycle wins, leaving `bor_n_o`=0.
- R10: A watchdog timeout while `chip_rst_o` is asserted is ignored. Flags and cause are unchanged after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_i | input | 1 | Power-on detect, active high; also the block's synchronous reset |
| bor_det_i | input | 1 | Brown-out detector output, active high |
| bor_en_i | input | 1 | Brown-out reset enable |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_tmo_i | input | 1 | Watchdog timeout pulse |
| sleep_i | input | 1 | Core is in sleep |
| xtal_mode_i | input | 1 | Crystal oscillator selected; enables the settle timer |
| sw_set_por_i | input | 1 | Software write that sets the power-on flag |
| sw_set_bor_i | input | 1 | Software write that sets the brown-out flag |
| chip_rst_o | output | 1 | Chip reset, active high |
| wake_o | output | 1 | One-cycle wake pulse after a sleep watchdog timeout |
| to_o | output | 1 | Timeout status flag |
| pd_o | output | 1 | Power-down status flag |
| por_n_o | output | 1 | Power-on flag, 0 after a power-on reset |
| bor_n_o | output | 1 | Brown-out flag, 0 after a brown-out reset |
| cause_o | output | 3 | Latest event: 0 power-on, 1 pin running, 2 pin sleep, 3 watchdog running, 4 watchdog wake, 5 brown-out |

## Verification
The bench measures the hold time for each cause to the exact edge. A timer that starts one count late, or a wrong choice of start path, shows up as `chip_rst_o` or `wake_o` moving one edge early or late, or 1024 edges off. A filter that counts samples wrongly passes the 3-cycle glitch to `chip_rst_o` within about seven edges, or misses the 4-cycle pulse. Flag and cause mistakes appear on the edge right after the event, so each scenario checks them at once against the value the previous scenario left behind.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int unsigned TIMER_CYCLES = 1024;
    localparam int unsigned PIN_SAMPLES  = 4;

    typedef enum logic [2:0] {
        S_RUN  = 3'd0,
        S_HOLD = 3'd1,
        S_PWRT = 3'd2,
        S_OST  = 3'd3,
        S_WOST = 3'd4
    } seq_state_e;

    typedef enum logic [2:0] {
        C_POWER_ON  = 3'd0,
        C_PIN_RUN   = 3'd1,
        C_PIN_SLEEP = 3'd2,
        C_WDT_RUN   = 3'd3,
        C_WDT_WAKE  = 3'd4,
        C_BROWNOUT  = 3'd5
    } rst_cause_e;

    typedef struct packed {
        logic to;
        logic pd;
        logic por_n;
        logic bor_n;
    } rst_flags_t;

    function automatic seq_state_e next_phase(input logic need_pwrt,
                                              input logic need_ost,
                                              input logic xtal);
        if (need_pwrt)           return S_PWRT;
        else if (need_ost && xtal) return S_OST;
        else                     return S_RUN;
    endfunction

endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int unsigned SAMPLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    output logic low_o
);
    localparam int unsigned CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], pin_n_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            low_q <= 1'b0;
        end else if (sync_q[1]) begin
            run_q <= '0;
            low_q <= 1'b0;
        end else if (run_q == LAST) begin
            low_q <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign low_o = low_q;
endmodule

// File: rtl/rstc_timer.sv
module rstc_timer #(
    parameter int unsigned CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
(
    input  logic       clk,
    input  logic       por_i,
    input  logic       bor_lvl_i,
    input  logic       pin_lvl_i,
    input  logic       wdt_tmo_i,
    input  logic       sleep_i,
    input  logic       xtal_mode_i,
    input  logic       sw_set_por_i,
    input  logic       sw_set_bor_i,
    input  logic       pwrt_done_i,
    input  logic       ost_done_i,
    output logic       pwrt_run_o,
    output logic       ost_run_o,
    output logic       chip_rst_o,
    output logic       wake_o,
    output rst_flags_t flags_o,
    output rst_cause_e cause_o
);
    seq_state_e state_q;
    seq_state_e after_hold;
    seq_state_e after_pwrt;
    logic       bor_q, pin_q;
    logic       need_pwrt_q, need_ost_q;
    logic       latch_q, wake_q;
    rst_flags_t flg_q;
    rst_cause_e cause_q;

    logic bor_rise, pin_rise, wdt_live;

    assign bor_rise   = bor_lvl_i && !bor_q;
    assign pin_rise   = pin_lvl_i && !pin_q;
    assign wdt_live   = wdt_tmo_i && (state_q == S_RUN);
    assign after_hold = next_phase(need_pwrt_q, need_ost_q, xtal_mode_i);
    assign after_pwrt = next_phase(1'b0, need_ost_q, xtal_mode_i);

    always_ff @(posedge clk) begin
        if (por_i) begin
            state_q     <= S_PWRT;
            bor_q       <= 1'b0;
            pin_q       <= 1'b0;
            need_pwrt_q <= 1'b1;
            need_ost_q  <= 1'b1;
            latch_q     <= 1'b1;
            wake_q      <= 1'b0;
            flg_q       <= '{to: 1'b1, pd: 1'b1, por_n: 1'b0, bor_n: 1'b1};
            cause_q     <= C_POWER_ON;
        end else begin
            bor_q  <= bor_lvl_i;
            pin_q  <= pin_lvl_i;
            wake_q <= 1'b0;
            if (sw_set_por_i) flg_q.por_n <= 1'b1;
            if (sw_set_bor_i) flg_q.bor_n <= 1'b1;

            if (bor_rise) begin
                state_q     <= S_HOLD;
                latch_q     <= 1'b1;
                need_pwrt_q <= 1'b1;
                need_ost_q  <= 1'b0;
                flg_q.bor_n <= 1'b0;
                cause_q     <= C_BROWNOUT;
            end else if (pin_rise) begin
                state_q     <= S_HOLD;
                latch_q     <= 1'b1;
                need_pwrt_q <= 1'b0;
                need_ost_q  <= sleep_i;
                if (sleep_i) begin
                    flg_q.to <= 1'b1;
                    flg_q.pd <= 1'b0;
                    cause_q  <= C_PIN_SLEEP;
                end else begin
                    cause_q  <= C_PIN_RUN;
                end
            end else if (wdt_live && !sleep_i) begin
                state_q     <= S_HOLD;
                latch_q     <= 1'b1;
                need_pwrt_q <= 1'b0;
                need_ost_q  <= 1'b0;
                flg_q.to    <= 1'b0;
                flg_q.pd    <= 1'b1;
                cause_q     <= C_WDT_RUN;
            end else if (wdt_live && sleep_i) begin
                flg_q.to <= 1'b0;
                flg_q.pd <= 1'b0;
                cause_q  <= C_WDT_WAKE;
                if (xtal_mode_i) state_q <= S_WOST;
                else             wake_q  <= 1'b1;
            end else begin
                unique case (state_q)
                    S_HOLD: begin
                        if (!bor_lvl_i && !pin_lvl_i) begin
                            state_q <= after_hold;
                            latch_q <= (after_hold != S_RUN);
                        end
                    end
                    S_PWRT: begin
                        if (pwrt_done_i) begin
                            state_q <= after_pwrt;
                            latch_q <= (after_pwrt != S_RUN);
                        end
                    end
                    S_OST: begin
                        if (ost_done_i) begin
                            state_q <= S_RUN;
                            latch_q <= 1'b0;
                        end
                    end
                    S_WOST: begin
                        if (ost_done_i) begin
                            state_q <= S_RUN;
                            wake_q  <= 1'b1;
                        end
                    end
                    default: begin
                        state_q <= S_RUN;
                    end
                endcase
            end
        end
    end

    assign pwrt_run_o = (state_q == S_PWRT);
    assign ost_run_o  = (state_q == S_OST) || (state_q == S_WOST);
    assign chip_rst_o = latch_q;
    assign wake_o     = wake_q;
    assign flags_o    = flg_q;
    assign cause_o    = cause_q;
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int unsigned PWRT_CYCLES = TIMER_CYCLES,
    parameter int unsigned OST_CYCLES  = TIMER_CYCLES,
    parameter int unsigned FILT_LEN    = PIN_SAMPLES
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       bor_det_i,
    input  logic       bor_en_i,
    input  logic       ext_rst_n_i,
    input  logic       wdt_tmo_i,
    input  logic       sleep_i,
    input  logic       xtal_mode_i,
    input  logic       sw_set_por_i,
    input  logic       sw_set_bor_i,
    output logic       chip_rst_o,
    output logic       wake_o,
    output logic       to_o,
    output logic       pd_o,
    output logic       por_n_o,
    output logic       bor_n_o,
    output logic [2:0] cause_o
);
    logic       pin_lvl;
    logic       bor_lvl;
    logic       pwrt_run, pwrt_done;
    logic       ost_run, ost_done;
    rst_flags_t flags;
    rst_cause_e cause;

    assign bor_lvl = bor_det_i && bor_en_i;

    rstc_pin_filter #(.SAMPLES(FILT_LEN)) u_filt (
        .clk     (clk),
        .rst     (por_i),
        .pin_n_i (ext_rst_n_i),
        .low_o   (pin_lvl)
    );

    rstc_timer #(.CYCLES(PWRT_CYCLES)) u_pwrt (
        .clk    (clk),
        .rst    (por_i),
        .run_i  (pwrt_run),
        .done_o (pwrt_done)
    );

    rstc_timer #(.CYCLES(OST_CYCLES)) u_ost (
        .clk    (clk),
        .rst    (por_i),
        .run_i  (ost_run),
        .done_o (ost_done)
    );

    rstc_seq u_seq (
        .clk          (clk),
        .por_i        (por_i),
        .bor_lvl_i    (bor_lvl),
        .pin_lvl_i    (pin_lvl),
        .wdt_tmo_i    (wdt_tmo_i),
        .sleep_i      (sleep_i),
        .xtal_mode_i  (xtal_mode_i),
        .sw_set_por_i (sw_set_por_i),
        .sw_set_bor_i (sw_set_bor_i),
        .pwrt_done_i  (pwrt_done),
        .ost_done_i   (ost_done),
        .pwrt_run_o   (pwrt_run),
        .ost_run_o    (ost_run),
        .chip_rst_o   (chip_rst_o),
        .wake_o       (wake_o),
        .flags_o      (flags),
        .cause_o      (cause)
    );

    assign to_o    = flags.to;
    assign pd_o    = flags.pd;
    assign por_n_o = flags.por_n;
    assign bor_n_o = flags.bor_n;
    assign cause_o = cause;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
    import rstc_pkg::*;
(
    input logic       clk,
    input logic       por_i,
    input logic       bor_det_i,
    input logic       bor_en_i,
    input logic       chip_rst_o,
    input logic       wake_o,
    input logic       to_o,
    input logic       pd_o,
    input logic       bor_n_o,
    input logic [2:0] cause_o,
    input logic       pin_lvl,
    input logic       bor_lvl
);
    AST_WAKE_NO_RESET: assert property (@(posedge clk) disable iff (por_i)
        wake_o |-> !chip_rst_o); // R8

    AST_WAKE_FLAGS: assert property (@(posedge clk) disable iff (por_i)
        wake_o |-> (!to_o && !pd_o)); // R8

    AST_BOR_GATED: assert property (@(posedge clk) disable iff (por_i)
        $fell(bor_n_o) |-> $past(bor_det_i && bor_en_i)); // R2

    AST_HOLD_WHILE_SRC: assert property (@(posedge clk) disable iff (por_i)
        (pin_lvl || bor_lvl) |=> chip_rst_o); // R4

    AST_RELEASE_SRC_CLEAR: assert property (@(posedge clk) disable iff (por_i)
        $fell(chip_rst_o) |-> $past(!pin_lvl && !bor_lvl)); // R3

    AST_WDT_RUN_PULSE: assert property (@(posedge clk) disable iff (por_i)
        ($rose(chip_rst_o) && cause_o == C_WDT_RUN) |=> !chip_rst_o); // R7

    AST_PIN_RUN_FLAGS: assert property (@(posedge clk) disable iff (por_i)
        ($rose(chip_rst_o) && cause_o == C_PIN_RUN) |-> ($stable(to_o) && $stable(pd_o))); // R5
endmodule

bind rstc_top rstc_checker u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .bor_det_i  (bor_det_i),
    .bor_en_i   (bor_en_i),
    .chip_rst_o (chip_rst_o),
    .wake_o     (wake_o),
    .to_o       (to_o),
    .pd_o       (pd_o),
    .bor_n_o    (bor_n_o),
    .cause_o    (cause_o),
    .pin_lvl    (pin_lvl),
    .bor_lvl    (bor_lvl)
);

// File: tb/rstc_top_tb_top.sv
module rstc_top_tb_top;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       bor_det = 1'b0;
    logic       bor_en = 1'b0;
    logic       pin_n = 1'b1;
    logic       wdt = 1'b0;
    logic       sleep = 1'b0;
    logic       xtal = 1'b0;
    logic       sw_por = 1'b0;
    logic       sw_bor = 1'b0;
    logic       chip_rst, wake, to_f, pd_f, por_n, bor_n;
    logic [2:0] cause;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_to = 1'b1;
    logic exp_pd = 1'b1;

    always #5 clk = ~clk;

    rstc_top dut_i (
        .clk          (clk),
        .por_i        (por),
        .bor_det_i    (bor_det),
        .bor_en_i     (bor_en),
        .ext_rst_n_i  (pin_n),
        .wdt_tmo_i    (wdt),
        .sleep_i      (sleep),
        .xtal_mode_i  (xtal),
        .sw_set_por_i (sw_por),
        .sw_set_bor_i (sw_bor),
        .chip_rst_o   (chip_rst),
        .wake_o       (wake),
        .to_o         (to_f),
        .pd_o         (pd_f),
        .por_n_o      (por_n),
        .bor_n_o      (bor_n),
        .cause_o      (cause)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        check({req, " to"}, 32'(to_f), 32'(exp_to));
        check({req, " pd"}, 32'(pd_f), 32'(exp_pd));
    endtask

    task automatic t_power_on(input logic xt);
        xtal = xt;
        por  = 1'b1;
        tick(3);
        check("R1 rst during por", 32'(chip_rst), 32'd1);
        check("R1 to", 32'(to_f), 32'd1);
        check("R1 pd", 32'(pd_f), 32'd1);
        check("R1 por_n", 32'(por_n), 32'd0);
        check("R1 bor_n", 32'(bor_n), 32'd1);
        check("R1 cause", 32'(cause), 32'd0);
        exp_to = 1'b1;
        exp_pd = 1'b1;
        por = 1'b0;
        tick(xt ? 2047 : 1023);
        check("R1 still held", 32'(chip_rst), 32'd1);
        tick(1);
        check("R1 released", 32'(chip_rst), 32'd0);
        xtal = 1'b0;
    endtask

    task automatic t_sw_flags();
        sw_por = 1'b1;
        tick(1);
        sw_por = 1'b0;
        check("R9 sw sets por_n", 32'(por_n), 32'd1);
    endtask

    task automatic t_bor_disabled();
        bor_en  = 1'b0;
        bor_det = 1'b1;
        tick(8);
        check("R2 no reset", 32'(chip_rst), 32'd0);
        check("R2 bor_n kept", 32'(bor_n), 32'd1);
        bor_det = 1'b0;
        tick(1);
    endtask

    task automatic t_brownout();
        xtal    = 1'b1;
        bor_en  = 1'b1;
        bor_det = 1'b1;
        sw_bor  = 1'b1;
        tick(1);
        sw_bor  = 1'b0;
        check("R3 reset asserted", 32'(chip_rst), 32'd1);
        check("R9 event beats sw set", 32'(bor_n), 32'd0);
        check("R3 cause", 32'(cause), 32'd5);
        tick(5);
        check("R3 held while low supply", 32'(chip_rst), 32'd1);
        bor_det = 1'b0;
        tick(1024);
        check("R3 held by timer", 32'(chip_rst), 32'd1);
        tick(1);
        check("R3 released", 32'(chip_rst), 32'd0);
        check_flags("R3");
        bor_en = 1'b0;
        xtal   = 1'b0;
    endtask

    task automatic t_wdt_run();
        wdt = 1'b1;
        tick(1);
        wdt = 1'b0;
        check("R7 pulse high", 32'(chip_rst), 32'd1);
        tick(1);
        check("R7 pulse one cycle", 32'(chip_rst), 32'd0);
        exp_to = 1'b0;
        exp_pd = 1'b1;
        check_flags("R7");
        check("R7 cause", 32'(cause), 32'd3);
    endtask

    task automatic t_pin_glitch();
        logic seen;
        pin_n = 1'b0;
        tick(3);
        pin_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (chip_rst) seen = 1'b1;
        end
        check("R4 short pulse ignored", 32'(seen), 32'd0);
        pin_n = 1'b0;
        tick(4);
        pin_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (chip_rst) seen = 1'b1;
        end
        check("R4 four samples reset", 32'(seen), 32'd1);
        check("R4 end released", 32'(chip_rst), 32'd0);
    endtask

    task automatic t_pin_run();
        pin_n = 1'b0;
        tick(10);
        check("R4 held while low", 32'(chip_rst), 32'd1);
        check("R5 cause", 32'(cause), 32'd1);
        check_flags("R5");
        wdt = 1'b1;
        tick(1);
        wdt = 1'b0;
        tick(20);
        check("R4 still held", 32'(chip_rst), 32'd1);
        pin_n = 1'b1;
        tick(3);
        check("R5 held to 3rd edge", 32'(chip_rst), 32'd1);
        tick(1);
        check("R5 released 4th edge", 32'(chip_rst), 32'd0);
        check_flags("R10 wdt ignored");
        check("R10 cause kept", 32'(cause), 32'd1);
    endtask

    task automatic t_pin_sleep();
        sleep = 1'b1;
        xtal  = 1'b1;
        pin_n = 1'b0;
        tick(10);
        exp_to = 1'b1;
        exp_pd = 1'b0;
        check("R6 reset", 32'(chip_rst), 32'd1);
        check_flags("R6");
        check("R6 cause", 32'(cause), 32'd2);
        pin_n = 1'b1;
        tick(4);
        check("R6 settle start", 32'(chip_rst), 32'd1);
        tick(1023);
        check("R6 settle end", 32'(chip_rst), 32'd1);
        tick(1);
        check("R6 released", 32'(chip_rst), 32'd0);
        xtal = 1'b0;
    endtask

    task automatic t_wdt_wake(input logic xt);
        sleep = 1'b1;
        xtal  = xt;
        wdt   = 1'b1;
        tick(1);
        wdt   = 1'b0;
        exp_to = 1'b0;
        exp_pd = 1'b0;
        check("R8 no reset", 32'(chip_rst), 32'd0);
        check_flags("R8");
        check("R8 cause", 32'(cause), 32'd4);
        if (!xt) begin
            check("R8 wake now", 32'(wake), 32'd1);
            tick(1);
            check("R8 wake one cycle", 32'(wake), 32'd0);
        end else begin
            check("R8 wake waits", 32'(wake), 32'd0);
            tick(1023);
            check("R8 wake still waits", 32'(wake), 32'd0);
            check("R8 no reset in settle", 32'(chip_rst), 32'd0);
            tick(1);
            check("R8 wake after settle", 32'(wake), 32'd1);
            tick(1);
            check("R8 wake drops", 32'(wake), 32'd0);
        end
        sleep = 1'b0;
        xtal  = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        tick(1);
        t_power_on(1'b0);
        t_sw_flags();
        t_bor_disabled();
        t_brownout();
        t_wdt_run();
        t_pin_glitch();
        t_pin_run();
        t_pin_sleep();
        t_wdt_wake(1'b0);
        t_wdt_wake(1'b1);
        t_power_on(1'b1);
        finish_run();
    end
endmodule